// File: doc/BRIEF.md
# Saturating Arithmetic Unit

This unit performs 32-bit arithmetic that clamps instead of wrapping. It covers signed and unsigned add and subtract, plus clamping of a value to a chosen bit position in signed or unsigned form. Both clamp operations also come in a dual form that treats each 16-bit half of the operand as its own signed number.

Any clamp that takes effect in any lane sets a sticky overflow flag. The flag stays set until a dedicated clear strobe removes it. An execution pipeline issues one operation per valid cycle. It reads the result one cycle later and polls the flag once a whole sequence has finished.

Top module: `sat_unit`

## Requirements
- R1: While rst_ni is low, result_o and sat_o are both 0.
- R2: Opcode 0 is a signed add and opcode 1 is a signed subtract. The result is the wrapped 32-bit value unless the true signed result falls outside the 32-bit range. In that case the result is 0x7FFFFFFF when a_i is non-negative and 0x80000000 when a_i is negative.
- R3: Opcode 2 is an unsigned add. If the true sum exceeds 0xFFFFFFFF the result is 0xFFFFFFFF, otherwise it is the sum.
- R4: Opcode 3 is an unsigned subtract. If b_i is greater than a_i the result is 0, otherwise it is a_i - b_i.
- R5: Opcode 4 clamps a_i, read as a signed number, to the range -(2^p) .. 2^p-1, where p is pos_i. With p = 31 the value always passes unchanged.
- R6: Opcode 5 clamps a_i, read as a signed number, to the range 0 .. 2^p-1.
- R7: Opcode 6 applies the R5 clamp and opcode 7 applies the R6 clamp, each to a_i[15:0] and a_i[31:16] separately. Each half is sign-extended before the clamp. The low 16 bits of each lane's result go back into that lane's own half.
- R8: A clamp that takes effect in any lane of an accepted operation sets sat_o. No arithmetic operation ever clears sat_o.
- R9: clr_i clears sat_o on the next edge. If an accepted operation clamps in the same cycle, sat_o is set instead.
- R10: With valid_i high, result_o shows the result one cycle later. With valid_i low, result_o holds its value and sat_o changes only through clr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation accepted this cycle |
| op_i | input | 3 | Opcode (see R2 to R7) |
| a_i | input | 32 | First operand / value to clamp |
| b_i | input | 32 | Second operand |
| pos_i | input | 5 | Clamp bit position p |
| clr_i | input | 1 | Clear strobe for the sticky flag |
| result_o | output | 32 | Registered result |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The bench targets sign-boundary operands: 0x7FFFFFFF, 0x80000000, all-ones and zero. A design that decides the clamp direction from the result's sign instead of the first operand's sign would return the wrong bound there.

Clamp positions 0 and 31 are exercised. A faulty mask width would either clamp everything at position 31 or miss the one-value range at position 0.

In the dual forms, half-lanes are driven in opposite directions. This exposes a design that uses one flag for both lanes or leaks one lane's sign into the other.

The bench also drives a clear and a clamp in the same cycle to show which wins. It then follows a clamp with clean operations, which catches a flag that an ordinary operation quietly overwrites.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [2:0] {
    OP_SADD   = 3'd0,
    OP_SSUB   = 3'd1,
    OP_UADD   = 3'd2,
    OP_USUB   = 3'd3,
    OP_SSAT   = 3'd4,
    OP_USAT   = 3'd5,
    OP_SSAT16 = 3'd6,
    OP_USAT16 = 3'd7
  } sat_op_e;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         signed_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0]   raw;
  logic [W-1:0] wrap;
  logic         s_ovf;
  logic         u_ovf;

  always_comb begin
    raw   = sub_i ? ({1'b0, a_i} - {1'b0, b_i}) : ({1'b0, a_i} + {1'b0, b_i});
    wrap  = raw[W-1:0];
    // same-sign add or opposite-sign subtract flipping the first operand's sign
    s_ovf = ((a_i[W-1] ^ b_i[W-1]) == sub_i) && (wrap[W-1] != a_i[W-1]);
    u_ovf = raw[W];
    if (signed_i) begin
      sat_o = s_ovf;
      res_o = s_ovf ? (a_i[W-1] ? SMIN : SMAX) : wrap;
    end else begin
      sat_o = u_ovf;
      res_o = u_ovf ? (sub_i ? '0 : '1) : wrap;
    end
  end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int W  = 32,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [PW-1:0] pos_i,
  input  logic          signed_i,
  output logic [W-1:0]  res_o,
  output logic          sat_o
);
  logic [W-1:0] mask;
  logic [W-1:0] top;
  logic         neg;
  logic         above;
  logic         below;

  always_comb begin
    mask = (W'(1) << pos_i) - W'(1);
    top  = W'($signed(val_i) >>> pos_i);
    neg  = val_i[W-1];
    if (signed_i) begin
      above = !neg && (|top);
      below = neg && !(&top);
    end else begin
      above = !neg && (|(val_i & ~mask));
      below = neg;
    end
    sat_o = above | below;
    if (above)      res_o = mask;
    else if (below) res_o = signed_i ? ~mask : '0;
    else            res_o = val_i;
  end
endmodule

// File: rtl/sat_unit.sv
module sat_unit
  import sat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] result_o,
  output logic              sat_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int LANES  = 3;

  sat_op_e           op;
  logic [DATA_W-1:0] as_res;
  logic              as_sat;
  logic [DATA_W-1:0] lane_in  [LANES];
  logic [DATA_W-1:0] lane_res [LANES];
  logic              lane_sat [LANES];
  logic              clamp_signed;
  logic [DATA_W-1:0] nxt_res;
  logic              nxt_sat;
  logic [DATA_W-1:0] res_q;
  logic              flag_q;

  assign op = sat_op_e'(op_i);

  sat_addsub #(.W(DATA_W)) u_addsub (
    .a_i      (a_i),
    .b_i      (b_i),
    .sub_i    (op_i[0]),
    .signed_i (!op_i[1]),
    .res_o    (as_res),
    .sat_o    (as_sat)
  );

  assign clamp_signed = (op == OP_SSAT) || (op == OP_SSAT16);

  // lane 0: full word; lanes 1..2: sign-extended halves
  assign lane_in[0] = a_i;
  assign lane_in[1] = {{HALF_W{a_i[HALF_W-1]}}, a_i[HALF_W-1:0]};
  assign lane_in[2] = {{HALF_W{a_i[DATA_W-1]}}, a_i[DATA_W-1:HALF_W]};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sat_clamp #(.W(DATA_W), .PW(POS_W)) u_clamp (
      .val_i    (lane_in[g]),
      .pos_i    (pos_i),
      .signed_i (clamp_signed),
      .res_o    (lane_res[g]),
      .sat_o    (lane_sat[g])
    );
  end

  always_comb begin
    unique case (op)
      OP_SADD, OP_SSUB, OP_UADD, OP_USUB: begin
        nxt_res = as_res;
        nxt_sat = as_sat;
      end
      OP_SSAT, OP_USAT: begin
        nxt_res = lane_res[0];
        nxt_sat = lane_sat[0];
      end
      default: begin
        nxt_res = {lane_res[2][HALF_W-1:0], lane_res[1][HALF_W-1:0]};
        nxt_sat = lane_sat[1] | lane_sat[2];
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (valid_i) res_q <= nxt_res;
      // a saturation in the same cycle outranks the clear
      flag_q <= (flag_q & ~clr_i) | (valid_i & nxt_sat);
    end
  end

  assign result_o = res_q;
  assign sat_o    = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o && !clr_i) |=> sat_o); // R8
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && nxt_sat) |=> sat_o); // R8
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(valid_i && nxt_sat)) |=> !sat_o); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R10
  AST_UADD_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2 && (DATA_W'(a_i + b_i) < a_i)) |=> (&result_o)); // R3
  AST_USUB_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd3 && (b_i > a_i)) |=> (result_o == '0)); // R4
  AST_SSAT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4 && (&pos_i)) |=> (result_o == $past(a_i))); // R5
endmodule

// File: tb/sat_unit_test.sv
module sat_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [4:0]  pos_i = '0;
  logic        clr_i = 1'b0;
  logic [31:0] result_o;
  logic        sat_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  logic [31:0] exp_res = '0;
  bit          exp_flag = 1'b0;

  sat_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .pos_i(pos_i), .clr_i(clr_i),
    .result_o(result_o), .sat_o(sat_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic longint clampv(longint v, longint lo, longint hi, output bit ev);
    ev = 1'b0;
    if (v > hi) begin ev = 1'b1; return hi; end
    if (v < lo) begin ev = 1'b1; return lo; end
    return v;
  endfunction

  function automatic longint sclamp(longint v, int p, output bit ev);
    return clampv(v, -(longint'(1) <<< p), (longint'(1) <<< p) - 1, ev);
  endfunction

  function automatic longint uclamp(longint v, int p, output bit ev);
    return clampv(v, 0, (longint'(1) <<< p) - 1, ev);
  endfunction

  function automatic logic [32:0] model(logic [2:0] op, logic [31:0] a, logic [31:0] b, int p);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ua = longint'({32'd0, a});
    longint ub = longint'({32'd0, b});
    longint lo_v = longint'($signed(a[15:0]));
    longint hi_v = longint'($signed(a[31:16]));
    longint r, rl, rh;
    bit e, e2;
    case (op)
      3'd0: r = clampv(sa + sb, -(longint'(1) <<< 31), (longint'(1) <<< 31) - 1, e);
      3'd1: r = clampv(sa - sb, -(longint'(1) <<< 31), (longint'(1) <<< 31) - 1, e);
      3'd2: r = clampv(ua + ub, 0, 64'hFFFF_FFFF, e);
      3'd3: r = clampv(ua - ub, 0, 64'hFFFF_FFFF, e);
      3'd4: r = sclamp(sa, p, e);
      3'd5: r = uclamp(sa, p, e);
      3'd6: begin
        rl = sclamp(lo_v, p, e); rh = sclamp(hi_v, p, e2);
        e = e | e2; r = (rh <<< 16) | (rl & 64'hFFFF);
      end
      default: begin
        rl = uclamp(lo_v, p, e); rh = uclamp(hi_v, p, e2);
        e = e | e2; r = (rh <<< 16) | (rl & 64'hFFFF);
      end
    endcase
    return {e, r[31:0]};
  endfunction

  function automatic string op_tag(logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [2:0] op, logic [31:0] a, logic [31:0] b,
                      logic [4:0] p, bit clr, string ftag);
    logic [32:0] m;
    valid_i = v; op_i = op; a_i = a; b_i = b; pos_i = p; clr_i = clr;
    m = model(op, a, b, int'(p));
    @(posedge clk_i); #1;
    if (v) exp_res = m[31:0];
    exp_flag = (exp_flag && !clr) || (v && m[32]);
    chk(result_o == exp_res, v ? op_tag(op) : "R10", result_o, exp_res);
    chk(sat_o == exp_flag, ftag, {31'd0, sat_o}, {31'd0, exp_flag});
    valid_i = 1'b0; clr_i = 1'b0;
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h7FFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0000_0000;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5A7E_0001));
    #(CLK_PERIOD * 3);
    chk(result_o == 32'd0, "R1", result_o, 32'd0);
    chk(sat_o == 1'b0, "R1", {31'd0, sat_o}, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;

    step(1, 3'd0, 32'd5, 32'hFFFF_FFFD, 0, 0, "R8");
    step(1, 3'd0, 32'h7FFF_FFFF, 32'd1, 0, 0, "R8");
    step(1, 3'd0, 32'd1, 32'd1, 0, 0, "R8");          // flag survives clean op
    step(0, 3'd0, 32'd0, 32'd0, 0, 1, "R9");
    step(1, 3'd0, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, "R8");
    step(1, 3'd1, 32'h8000_0000, 32'd1, 0, 1, "R9");   // clear loses to saturation
    step(1, 3'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 1, "R9");
    step(1, 3'd1, 32'd0, 32'h8000_0000, 0, 1, "R9");
    step(1, 3'd2, 32'hFFFF_FFFF, 32'd1, 0, 1, "R9");
    step(1, 3'd3, 32'd5, 32'd5, 0, 1, "R9");
    step(1, 3'd3, 32'd3, 32'd5, 0, 1, "R9");
    step(1, 3'd4, 32'd200, 32'd0, 7, 1, "R9");
    step(1, 3'd4, 32'hFFFF_FF38, 32'd0, 7, 1, "R9");
    step(1, 3'd4, 32'h8000_0000, 32'd0, 31, 1, "R9");
    step(1, 3'd4, 32'hFFFF_FFFF, 32'd0, 0, 1, "R9");
    step(1, 3'd5, 32'hFFFF_FFFF, 32'd0, 8, 1, "R9");
    step(1, 3'd5, 32'd300, 32'd0, 8, 1, "R9");
    step(1, 3'd5, 32'd1, 32'd0, 0, 1, "R9");
    step(1, 3'd6, 32'h8000_7FFF, 32'd0, 7, 1, "R9");
    step(1, 3'd7, 32'hFFF0_0020, 32'd0, 4, 1, "R9");
    step(1, 3'd6, 32'h1234_8000, 32'd0, 15, 1, "R9");
    step(0, 3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R10");
    step(0, 3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, "R9");

    for (int i = 0; i < 2000; i++) begin
      step($urandom_range(0, 7) != 0, 3'($urandom_range(0, 7)), pick(), pick(),
           5'($urandom_range(0, 31)), $urandom_range(0, 7) == 0, "R8");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule